// File: doc/BRIEF.md
# Periodic Drive-Strength Calibration Controller

This block holds the strength setting of an output driver close to the value set by an external reference resistor. A free-running interval counter starts an evaluation once every 1024 enabled clock cycles. In that evaluation cycle the block reads one comparator bit and moves a binary-weighted drive code by a single step. A 1 on the comparator means the driver is too weak, so the code goes up. A 0 means the driver is too strong, so the code goes down. The code stops at either end of its range. Because each correction is one least-significant step on a slow fixed cadence, the setting follows supply and temperature drift gradually and does not jump to a target.

The loop runs for as long as the enable input is high. Dropping the enable freezes the code and clears the interval counter, so a new full interval begins when the enable returns. The code is held in a register and changes only on the clock edge that ends an evaluation cycle. The analog driver therefore never sees an intermediate value. A one-cycle strobe marks each evaluation cycle.

Top module: `zcal_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `drive_code` is 32 (6'b100000, the mid-scale value) and `eval_pulse` is 0.
- R2: With `cal_en` held high, `eval_pulse` is high for exactly one cycle in each run of 1024 cycles. It first rises 1023 rising edges after reset is released or after `cal_en` rises. After that it recurs exactly 1024 cycles after the previous strobe.
- R3: If `drv_weak` is 1 in a cycle where `eval_pulse` is high and `drive_code` is below 63, `drive_code` rises by exactly 1 at the next rising edge.
- R4: If `drv_weak` is 0 in a cycle where `eval_pulse` is high and `drive_code` is above 0, `drive_code` falls by exactly 1 at the next rising edge.
- R5: The value of `drv_weak` in any cycle without `eval_pulse` has no effect on `drive_code`.
- R6: An evaluation with `drv_weak` = 1 while `drive_code` is 63 leaves the code at 63; it never wraps to 0.
- R7: An evaluation with `drv_weak` = 0 while `drive_code` is 0 leaves the code at 0; it never wraps to 63.
- R8: While `cal_en` is low, `eval_pulse` stays 0, `drive_code` does not change and the interval counter is held at zero.
- R9: `drive_code` comes from a register and changes only on the rising edge that directly follows a cycle with `eval_pulse` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_en | input | 1 | High lets the calibration loop run; low freezes the code and clears the counter |
| drv_weak | input | 1 | Comparator result: 1 means the driver is too weak, 0 means too strong |
| drive_code | output | CODE_W (6) | Registered binary-weighted drive-strength code |
| eval_pulse | output | 1 | High during each evaluation cycle |

## Verification
If the interval counter holds a wrong value, it shows first as a misplaced `eval_pulse`. That shift appears within one interval, at most 1024 cycles. A wrong code register can only become visible at an evaluation, so it may stay hidden for a whole interval. The bench therefore checks the code both just before and just after every strobe, holding `drv_weak` at the opposite value between strobes. A stepper that reads the comparator outside the evaluation cycle, or that wraps at either end, then changes the port value by a full step or by the whole range at the very next edge.

// File: rtl/zcal_pkg.sv
package zcal_pkg;
   // Direction of one calibration step, taken straight from the comparator bit.
   typedef enum logic {
      ZC_WEAKEN     = 1'b0,
      ZC_STRENGTHEN = 1'b1
   } zc_dir_e;
endpackage

// File: rtl/zcal_interval_timer.sv
module zcal_interval_timer #(
   parameter int unsigned INTERVAL = 1024,
   parameter int unsigned CNT_W    = $clog2(INTERVAL)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic eval_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam bit IS_POW2 = ((INTERVAL & (INTERVAL - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             at_last;

   assign at_last = (cnt_q == LAST);

   generate
      if (IS_POW2) begin : g_pow2
         // Natural wrap of the counter width ends the interval.
         assign cnt_nxt = cnt_q + ONE;
      end else begin : g_cmp
         assign cnt_nxt = at_last ? '0 : cnt_q + ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
      end
   end

   assign eval_o = run & at_last;
endmodule

// File: rtl/zcal_code_stepper.sv
module zcal_code_stepper
   import zcal_pkg::*;
#(
   parameter int unsigned CODE_W     = 6,
   parameter int unsigned RESET_CODE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_i,
   input  zc_dir_e           dir_i,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] BOT_CODE = '0;
   localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);
   localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(RESET_CODE);

   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] code_nxt;

   always_comb begin
      code_nxt = code_q;
      if (dir_i == ZC_STRENGTHEN) begin
         if (code_q != TOP_CODE) code_nxt = code_q + ONE;
      end else begin
         if (code_q != BOT_CODE) code_nxt = code_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= RST_CODE;
      end else if (eval_i) begin
         code_q <= code_nxt;
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/zcal_ctrl.sv
module zcal_ctrl
   import zcal_pkg::*;
#(
   parameter int unsigned CODE_W     = 6,
   parameter int unsigned INTERVAL   = 1024,
   parameter int unsigned RESET_CODE = 1 << (CODE_W - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_en,
   input  logic              drv_weak,
   output logic [CODE_W-1:0] drive_code,
   output logic              eval_pulse
);
   localparam int unsigned CNT_W = $clog2(INTERVAL);

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code_w
         $error("zcal_ctrl: CODE_W must lie in 2..16");
      end
      if (INTERVAL < 2) begin : g_bad_interval
         $error("zcal_ctrl: INTERVAL must be at least 2");
      end
      if (RESET_CODE >= (1 << CODE_W)) begin : g_bad_reset
         $error("zcal_ctrl: RESET_CODE does not fit in CODE_W bits");
      end
   endgenerate

   logic eval_w;

   zcal_interval_timer #(
      .INTERVAL (INTERVAL),
      .CNT_W    (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (cal_en),
      .eval_o (eval_w)
   );

   zcal_code_stepper #(
      .CODE_W     (CODE_W),
      .RESET_CODE (RESET_CODE)
   ) u_stepper (
      .clk    (clk),
      .rst_n  (rst_n),
      .eval_i (eval_w),
      .dir_i  (zc_dir_e'(drv_weak)),
      .code_o (drive_code)
   );

   assign eval_pulse = eval_w;
endmodule

// File: rtl/zcal_ctrl_chk.sv
module zcal_ctrl_chk #(
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned INTERVAL = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cal_en,
   input logic              drv_weak,
   input logic [CODE_W-1:0] drive_code,
   input logic              eval_pulse
);
   localparam int unsigned GAP_W = $clog2(INTERVAL) + 1;
   localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(INTERVAL - 1);
   localparam logic [GAP_W-1:0]  GAP_ONE  = GAP_W'(1);
   localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

   // Enabled edges seen since the last strobe or since the enable was low.
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= '0;
      else if (!cal_en || eval_pulse) gap_q <= '0;
      else if (gap_q != {GAP_W{1'b1}}) gap_q <= gap_q + GAP_ONE;
   end

   assert_gap_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eval_pulse |-> (gap_q == GAP_LAST));

   assert_gap_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_en && gap_q == GAP_LAST) |-> eval_pulse);

   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_pulse && drv_weak && drive_code != TOP_CODE) |=>
         (drive_code == $past(drive_code) + ONE));

   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_pulse && !drv_weak && drive_code != '0) |=>
         (drive_code == $past(drive_code) - ONE));

   assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_pulse && drv_weak && drive_code == TOP_CODE) |=> (drive_code == TOP_CODE));

   assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_pulse && !drv_weak && drive_code == '0) |=> (drive_code == '0));

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_en |=> $stable(drive_code));

   assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_en |-> !eval_pulse);

   assert_change_after_eval_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_pulse |=> $stable(drive_code));
endmodule

bind zcal_ctrl zcal_ctrl_chk #(
   .CODE_W   (CODE_W),
   .INTERVAL (INTERVAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cal_en     (cal_en),
   .drv_weak   (drv_weak),
   .drive_code (drive_code),
   .eval_pulse (eval_pulse)
);

// File: tb/zcal_ctrl_bench.sv
`timescale 1ns/1ps
module zcal_ctrl_bench;
   localparam int CODE_W = 6;
   localparam int MAXC   = (1 << CODE_W) - 1;
   localparam int MID    = 32;
   localparam int GAP    = 1023;  // negedges counted from the one after a strobe

   // Each entry: comparator bit for one evaluation, expected code after it.
   localparam int NVEC = 8;
   localparam logic [6:0] VEC [NVEC] = '{
      {1'b1, 6'd33}, {1'b1, 6'd34}, {1'b0, 6'd33}, {1'b0, 6'd32},
      {1'b0, 6'd31}, {1'b1, 6'd32}, {1'b1, 6'd33}, {1'b1, 6'd34}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cal_en = 1'b1;
   logic              drv_weak = 1'b0;
   logic [CODE_W-1:0] drive_code;
   logic              eval_pulse;

   int n_checks = 0;
   int n_errors = 0;
   int exp_code = MID;

   always #2.5 clk = ~clk;

   zcal_ctrl u_zcal_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_en     (cal_en),
      .drv_weak   (drv_weak),
      .drive_code (drive_code),
      .eval_pulse (eval_pulse)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // One evaluation: comparator held at the opposite value between strobes,
   // set to c only in the strobe cycle.
   task automatic do_eval(input string req, input logic c, input int exp_gap);
      int n = 0;
      drv_weak = ~c;
      do begin
         @(negedge clk);
         n++;
      end while (!eval_pulse && n < 3000);
      chk("R2 gap", n, exp_gap);
      chk("R5 code held before strobe", int'(drive_code), exp_code);
      drv_weak = c;
      if (c) exp_code = (exp_code == MAXC) ? MAXC : exp_code + 1;
      else   exp_code = (exp_code == 0) ? 0 : exp_code - 1;
      @(negedge clk);
      chk(req, int'(drive_code), exp_code);
      chk("R2 one-cycle strobe", int'(eval_pulse), 0);
      drv_weak = ~c;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 code in reset", int'(drive_code), MID);
      chk("R1 strobe in reset", int'(eval_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 code after release", int'(drive_code), MID);
      // exactly one negedge consumed, so first strobe is 1022 more negedges away
      do_eval("R3 first eval", 1'b1, GAP - 1);

      // Table walk: R3 / R4 alternating directions, R9 timing inside do_eval
      for (int i = 1; i < NVEC; i++) begin
         do_eval(VEC[i][6] ? "R3 table" : "R4 table", VEC[i][6], GAP);
         chk("R9 table code", int'(drive_code), int'(VEC[i][5:0]));
      end

      // R8: disable mid-interval, code frozen, no strobe, counter restarts
      begin
         int bad_pulse = 0;
         int bad_code = 0;
         repeat (300) @(negedge clk);
         cal_en = 1'b0;
         for (int k = 0; k < 1500; k++) begin
            drv_weak = k[0];
            @(negedge clk);
            if (eval_pulse) bad_pulse++;
            if (int'(drive_code) != exp_code) bad_code++;
         end
         chk("R8 no strobe while disabled", bad_pulse, 0);
         chk("R8 code frozen while disabled", bad_code, 0);
         cal_en = 1'b1;
         do_eval("R8 restart then R4", 1'b0, GAP);
      end

      // R6: climb to the top and push past it
      while (exp_code < MAXC) do_eval("R3 climb", 1'b1, GAP);
      chk("R6 reached top", int'(drive_code), MAXC);
      do_eval("R6 hold at top", 1'b1, GAP);
      do_eval("R6 hold at top again", 1'b1, GAP);

      // R7: descend to zero and push past it
      while (exp_code > 0) do_eval("R4 descend", 1'b0, GAP);
      chk("R7 reached bottom", int'(drive_code), 0);
      do_eval("R7 hold at bottom", 1'b0, GAP);
      do_eval("R7 hold at bottom again", 1'b0, GAP);

      // R1: asynchronous reset mid-run returns to mid-scale
      repeat (100) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 code on mid-run reset", int'(drive_code), MID);
      chk("R1 strobe on mid-run reset", int'(eval_pulse), 0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_code = MID;
      do_eval("R3 after second reset", 1'b1, GAP);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule